// File: doc/BRIEF.md
# Two-Wire Serial Program/Verify Target Engine

This block is the device-side end of a two-wire programming link. An external programmer toggles a serial clock pin and drives or samples one shared data pin. The engine shifts in six-bit commands, receives or transmits sixteen-cycle data frames that carry a 14-bit word between a leading and a trailing zero, and controls when the data pin is driven. It turns each accepted command into a single-cycle strobe on a one-hot vector. For loads it presents the received word together with the strobe, and for reads it takes a word from the memory side and sends it back.

Both pins are oversampled by a faster system clock: each passes through a synchroniser, and the engine acts only on edges it detects in the synchronised serial clock. The actual nonvolatile writes and their timers sit outside this block. A program-mode enable holds the engine idle while low, so entering or leaving program mode always restarts the protocol from a fresh command.

Top module: `sprog_slave`

## Requirements
- R1: While `rst_n` is low or `prog_en` is low, `sdat_pin_oe` is 0 and `op_pulse` is all zeros. Dropping `prog_en` in the middle of a command or frame discards it, and the first six clocks after `prog_en` rises again form a new command.
- R2: A command is six serial clock cycles. Its bits are taken from the data pin at each falling clock edge, least significant bit first. Codes (MSB..LSB) and `op_pulse` bit: 000000 load configuration (0), 000010 load program word (1), 000011 load data-memory byte (2), 000100 read program word (3), 000101 read data-memory byte (4), 000110 increment (5), 001000 begin erase+program (6), 011000 begin program-only (7), 001001 bulk erase program (8), 001011 bulk erase data (9).
- R3: Increment, both begin commands and both bulk erases pulse their `op_pulse` bit after the sixth falling edge, and the next serial cycle starts a new command (no data frame).
- R4: A load command is followed by a 16-cycle frame. Falling edges 2 to 15 deliver data bits 0 to 13. At the 16th falling edge the command's `op_pulse` bit pulses, and `wdata` holds the word in that same cycle.
- R5: For the load data-memory command only data bits 0 to 7 are kept, and `wdata` bits 13 to 8 read 0.
- R6: A read command pulses its `op_pulse` bit after the sixth falling edge. `rdata` is captured at the first rising edge of the following frame. `sdat_pin_oe` stays 0 through that first cycle, goes to 1 at the second rising edge, and from rising edge k+2 the pin carries data bit k.
- R7: `sdat_pin_oe` returns to 0 at the 16th rising edge of a read frame, and the next cycle after the frame starts a command.
- R8: The read data-memory command sends `rdata` bits 0 to 7, and the data pin is driven 0 for frame bits 8 to 13.
- R9: A six-bit code not listed in R2 produces no pulse and no data frame, and the next six cycles are taken as a new command.
- R10: `op_pulse` never has more than one bit set, and each accepted command pulses exactly once, for one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Program mode active; low holds all protocol state cleared |
| sclk_pin | input | 1 | Serial clock from the programmer |
| sdat_pin_in | input | 1 | Data pin input value |
| sdat_pin_out | output | 1 | Data pin value driven during reads |
| sdat_pin_oe | output | 1 | Data pin output enable |
| rdata | input | WORD_W | Word returned by memory for read commands |
| op_pulse | output | 10 | One-hot command strobes, bit order as in R2 |
| wdata | output | WORD_W | Received load word, valid with a load strobe |

## Verification
A wrong bit counter or a wrong frame state inside the engine shows at the ports within one command. A load strobe comes at the wrong serial cycle or with shifted data, a strobe is missing or extra on the next command, or the data pin output enable rises or falls on the wrong rising edge of a read frame. The scoreboard matches every strobe and load word against the queue of expected commands as soon as it appears. The read checks sample the pin a few system clocks after each serial rising edge, so a turnaround that is off by one edge is caught in the cycle where it goes wrong.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

   localparam int SP_CMD_W   = 6;
   localparam int SP_NUM_OPS = 10;

   typedef enum logic [3:0] {
      OP_LD_CFG  = 4'd0,
      OP_LD_PGM  = 4'd1,
      OP_LD_DAT  = 4'd2,
      OP_RD_PGM  = 4'd3,
      OP_RD_DAT  = 4'd4,
      OP_INC     = 4'd5,
      OP_BEG_EP  = 4'd6,
      OP_BEG_PO  = 4'd7,
      OP_ERA_PGM = 4'd8,
      OP_ERA_DAT = 4'd9
   } sp_op_e;

   typedef enum logic [1:0] {
      FK_NONE = 2'd0,
      FK_LOAD = 2'd1,
      FK_READ = 2'd2
   } sp_frame_e;

   typedef enum logic [1:0] {
      ST_CMD  = 2'd0,
      ST_LOAD = 2'd1,
      ST_READ = 2'd2
   } sp_state_e;

   typedef struct packed {
      logic      hit;
      sp_op_e    op;
      sp_frame_e kind;
      logic      dmem;
   } sp_dec_t;

   function automatic sp_dec_t sp_decode(input logic [SP_CMD_W-1:0] code);
      sp_dec_t d;
      d.hit  = 1'b1;
      d.op   = OP_INC;
      d.kind = FK_NONE;
      d.dmem = 1'b0;
      case (code)
         6'b000000: begin d.op = OP_LD_CFG; d.kind = FK_LOAD; end
         6'b000010: begin d.op = OP_LD_PGM; d.kind = FK_LOAD; end
         6'b000011: begin d.op = OP_LD_DAT; d.kind = FK_LOAD; d.dmem = 1'b1; end
         6'b000100: begin d.op = OP_RD_PGM; d.kind = FK_READ; end
         6'b000101: begin d.op = OP_RD_DAT; d.kind = FK_READ; d.dmem = 1'b1; end
         6'b000110: d.op = OP_INC;
         6'b001000: d.op = OP_BEG_EP;
         6'b011000: d.op = OP_BEG_PO;
         6'b001001: d.op = OP_ERA_PGM;
         6'b001011: d.op = OP_ERA_DAT;
         default:   d.hit = 1'b0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic din,
   output logic q,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sprog_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RESET_VAL}};
         last  <= RESET_VAL;
      end else if (clr) begin
         chain <= {STAGES{RESET_VAL}};
         last  <= RESET_VAL;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         last  <= chain[STAGES-1];
      end
   end

   assign q    = chain[STAGES-1];
   assign rise =  chain[STAGES-1] & ~last;
   assign fall = ~chain[STAGES-1] &  last;

endmodule

// File: rtl/sprog_tx.sv
module sprog_tx #(
   parameter int WORD_W = 14,
   parameter int DMEM_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cap,
   input  logic              cap_dmem,
   input  logic [WORD_W-1:0] word,
   input  logic              drive,
   input  logic              release_i,
   output logic              dout,
   output logic              oe
);
   logic [WORD_W-1:0] mask;
   logic [WORD_W-1:0] sh;

   generate
      if (DMEM_W >= WORD_W) begin : g_full_mask
         assign mask = '1;
      end else begin : g_part_mask
         assign mask = {{(WORD_W-DMEM_W){1'b0}}, {DMEM_W{1'b1}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         dout <= 1'b0;
         oe   <= 1'b0;
      end else if (clr) begin
         sh   <= '0;
         dout <= 1'b0;
         oe   <= 1'b0;
      end else begin
         if (cap) begin
            sh <= cap_dmem ? (word & mask) : word;
         end
         if (drive) begin
            dout <= sh[0];
            sh   <= sh >> 1;
            oe   <= 1'b1;
         end
         if (release_i) begin
            dout <= 1'b0;
            oe   <= 1'b0;
         end
      end
   end

   a_r7_release_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
      (release_i && !clr) |=> (!oe && !dout));

endmodule

// File: rtl/sprog_engine.sv
module sprog_engine
   import sprog_pkg::*;
#(
   parameter int WORD_W = 14,
   parameter int DMEM_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  rise,
   input  logic                  fall,
   input  logic                  din,
   output logic [SP_NUM_OPS-1:0] op_pulse,
   output logic [WORD_W-1:0]     wdata,
   output logic                  tx_cap,
   output logic                  tx_dmem,
   output logic                  tx_drive,
   output logic                  tx_release
);
   localparam int FRAME_N = WORD_W + 2;
   localparam int CNT_W   = $clog2(FRAME_N + 1);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_N - 1);
   localparam logic [CNT_W-1:0] CMD_C  = CNT_W'(SP_CMD_W - 1);
   localparam logic [CNT_W-1:0] WORD_C = CNT_W'(WORD_W);

   logic [WORD_W-1:0] mask;
   generate
      if (DMEM_W >= WORD_W) begin : g_full_mask
         assign mask = '1;
      end else begin : g_part_mask
         assign mask = {{(WORD_W-DMEM_W){1'b0}}, {DMEM_W{1'b1}}};
      end
   endgenerate

   sp_state_e           st;
   logic [CNT_W-1:0]    cnt;
   logic [SP_CMD_W-1:0] cmd_sh;
   logic [SP_CMD_W-1:0] nxt_cmd;
   logic [WORD_W-1:0]   rx_sh;
   sp_op_e              cur_op;
   logic                cur_dmem;
   sp_dec_t             dec;

   assign nxt_cmd = {din, cmd_sh[SP_CMD_W-1:1]};
   assign dec     = sp_decode(nxt_cmd);

   assign tx_cap     = (st == ST_READ) && rise && (cnt == '0);
   assign tx_drive   = (st == ST_READ) && rise && (cnt != '0) && (cnt <= WORD_C);
   assign tx_release = (st == ST_READ) && rise && (cnt == LAST_C);
   assign tx_dmem    = cur_dmem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_CMD;
         cnt      <= '0;
         cmd_sh   <= '0;
         rx_sh    <= '0;
         cur_op   <= OP_INC;
         cur_dmem <= 1'b0;
         op_pulse <= '0;
         wdata    <= '0;
      end else if (clr) begin
         st       <= ST_CMD;
         cnt      <= '0;
         cmd_sh   <= '0;
         rx_sh    <= '0;
         cur_op   <= OP_INC;
         cur_dmem <= 1'b0;
         op_pulse <= '0;
         wdata    <= '0;
      end else begin
         op_pulse <= '0;
         if (fall) begin
            case (st)
               ST_CMD: begin
                  if (cnt == CMD_C) begin
                     cnt    <= '0;
                     cmd_sh <= '0;
                     if (dec.hit) begin
                        cur_op   <= dec.op;
                        cur_dmem <= dec.dmem;
                        case (dec.kind)
                           FK_LOAD: st <= ST_LOAD;
                           FK_READ: begin
                              st                <= ST_READ;
                              op_pulse[dec.op]  <= 1'b1;
                           end
                           default: op_pulse[dec.op] <= 1'b1;
                        endcase
                     end
                  end else begin
                     cnt    <= cnt + 1'b1;
                     cmd_sh <= nxt_cmd;
                  end
               end
               ST_LOAD: begin
                  if ((cnt != '0) && (cnt <= WORD_C)) begin
                     rx_sh <= {din, rx_sh[WORD_W-1:1]};
                  end
                  if (cnt == LAST_C) begin
                     st               <= ST_CMD;
                     cnt              <= '0;
                     op_pulse[cur_op] <= 1'b1;
                     wdata            <= cur_dmem ? (rx_sh & mask) : rx_sh;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_READ: begin
                  if (cnt == LAST_C) begin
                     st  <= ST_CMD;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  st  <= ST_CMD;
                  cnt <= '0;
               end
            endcase
         end
      end
   end

   // R10: at most one strobe at a time
   a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(op_pulse));

   // R3: frameless commands leave the engine waiting for a command
   a_r3_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (op_pulse[OP_INC] || op_pulse[OP_BEG_EP] || op_pulse[OP_BEG_PO] ||
       op_pulse[OP_ERA_PGM] || op_pulse[OP_ERA_DAT]) |-> (st == ST_CMD));

   // R6: a read strobe is followed by a read frame
   a_r6_read_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (op_pulse[OP_RD_PGM] || op_pulse[OP_RD_DAT]) |-> (st == ST_READ));

   generate
      if (DMEM_W < WORD_W) begin : g_dmem_chk
         // R5: data-memory load word carries no upper bits
         a_r5_dat_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            op_pulse[OP_LD_DAT] |-> (wdata[WORD_W-1:DMEM_W] == '0));
      end
   endgenerate

endmodule

// File: rtl/sprog_slave.sv
module sprog_slave
   import sprog_pkg::*;
#(
   parameter int WORD_W = 14,
   parameter int DMEM_W = 8,
   parameter int SYNC_N = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  prog_en,
   input  logic                  sclk_pin,
   input  logic                  sdat_pin_in,
   output logic                  sdat_pin_out,
   output logic                  sdat_pin_oe,
   input  logic [WORD_W-1:0]     rdata,
   output logic [SP_NUM_OPS-1:0] op_pulse,
   output logic [WORD_W-1:0]     wdata
);
   generate
      if (DMEM_W < 1 || DMEM_W > WORD_W) begin : g_bad_dmem
         $error("sprog_slave: DMEM_W must lie in 1..WORD_W");
      end
      if (WORD_W < SP_CMD_W) begin : g_bad_word
         $error("sprog_slave: WORD_W must not be below the command width");
      end
   endgenerate

   logic clr;
   logic clk_q, clk_rise, clk_fall;
   logic dat_q, dat_rise_unused, dat_fall_unused;
   logic tx_cap, tx_dmem, tx_drive, tx_release;

   assign clr = ~prog_en;

   sprog_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b0)) u_clk_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .din   (sclk_pin),
      .q     (clk_q),
      .rise  (clk_rise),
      .fall  (clk_fall)
   );

   sprog_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b0)) u_dat_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .din   (sdat_pin_in),
      .q     (dat_q),
      .rise  (dat_rise_unused),
      .fall  (dat_fall_unused)
   );

   sprog_engine #(.WORD_W(WORD_W), .DMEM_W(DMEM_W)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .rise       (clk_rise),
      .fall       (clk_fall),
      .din        (dat_q),
      .op_pulse   (op_pulse),
      .wdata      (wdata),
      .tx_cap     (tx_cap),
      .tx_dmem    (tx_dmem),
      .tx_drive   (tx_drive),
      .tx_release (tx_release)
   );

   sprog_tx #(.WORD_W(WORD_W), .DMEM_W(DMEM_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .cap       (tx_cap),
      .cap_dmem  (tx_dmem),
      .word      (rdata),
      .drive     (tx_drive),
      .release_i (tx_release),
      .dout      (sdat_pin_out),
      .oe        (sdat_pin_oe)
   );

   // R1: out of program mode the pin is released and no strobe appears
   a_r1_idle_out_of_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_en |=> (!sdat_pin_oe && (op_pulse == '0)));

   // R6: the pin turns to output only on a serial rising edge
   a_r6_oe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdat_pin_oe) |-> $past(clk_rise));

   // R7: the pin is released on a serial rising edge or by leaving program mode
   a_r7_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sdat_pin_oe) |-> ($past(clk_rise) || $past(clr)));

   // R2: a strobe follows a serial falling edge
   a_r2_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (op_pulse != '0) |-> $past(clk_fall));

   logic unused_ok;
   assign unused_ok = clk_q ^ dat_rise_unused ^ dat_fall_unused;

endmodule

// File: tb/sprog_slave_test.sv
module sprog_slave_test;
   localparam int HALF = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prog_en = 1'b0;
   logic        sclk_pin = 1'b0;
   logic        sdat_pin_in = 1'b0;
   logic        sdat_pin_out;
   logic        sdat_pin_oe;
   logic [13:0] rdata = '0;
   logic [9:0]  op_pulse;
   logic [13:0] wdata;

   always #4 clk = ~clk;

   sprog_slave uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .prog_en      (prog_en),
      .sclk_pin     (sclk_pin),
      .sdat_pin_in  (sdat_pin_in),
      .sdat_pin_out (sdat_pin_out),
      .sdat_pin_oe  (sdat_pin_oe),
      .rdata        (rdata),
      .op_pulse     (op_pulse),
      .wdata        (wdata)
   );

   typedef struct {
      int          idx;
      logic [13:0] d;
      bit          cd;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad   = 0;
   bit   done  = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic scyc(input logic d);
      sdat_pin_in = d;
      sclk_pin = 1'b1;
      wclk(HALF);
      sclk_pin = 1'b0;
      wclk(HALF);
   endtask

   task automatic send_cmd(input logic [5:0] c);
      for (int i = 0; i < 6; i++) scyc(c[i]);
      wclk(4);
   endtask

   task automatic expect_op(input int idx, input logic [13:0] d, input bit cd, input string tag);
      exp_t e;
      e.idx = idx; e.d = d; e.cd = cd; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic do_load(input logic [5:0] c, input int idx, input logic [13:0] w,
                          input bit dm, input string tag);
      expect_op(idx, dm ? (w & 14'h00FF) : w, 1'b1, tag);
      send_cmd(c);
      scyc(1'b0);
      for (int i = 0; i < 14; i++) scyc(w[i]);
      scyc(1'b0);
      wclk(4);
   endtask

   task automatic do_read(input logic [5:0] c, input int idx, input logic [13:0] w, input bit dm);
      logic [13:0] ex;
      ex = dm ? (w & 14'h00FF) : w;
      rdata = w;
      expect_op(idx, '0, 1'b0, "R6 read strobe");
      send_cmd(c);
      for (int k = 1; k <= 16; k++) begin
         sdat_pin_in = 1'b0;
         sclk_pin = 1'b1;
         wclk(5);
         if (k == 1) begin
            chk("R6 oe low in first cycle", {31'd0, sdat_pin_oe}, 32'd0);
            rdata = ~w;
         end else if (k <= 15) begin
            chk("R6 oe high", {31'd0, sdat_pin_oe}, 32'd1);
            if (dm && (k - 2) >= 8)
               chk("R8 upper bit driven low", {31'd0, sdat_pin_out}, {31'd0, ex[k-2]});
            else
               chk("R6 data bit", {31'd0, sdat_pin_out}, {31'd0, ex[k-2]});
         end else begin
            chk("R7 oe released at 16th rise", {31'd0, sdat_pin_oe}, 32'd0);
         end
         wclk(HALF - 5);
         sclk_pin = 1'b0;
         wclk(HALF);
      end
      wclk(4);
   endtask

   task automatic summary;
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // monitor: compares every strobe with the expected queue
   logic [9:0] prev_op = '0;
   always @(negedge clk) begin
      if (rst_n && op_pulse != '0) begin
         chk("R10 pulse one cycle wide", {22'd0, prev_op}, 32'd0);
         if (q.size() == 0) begin
            total++;
            bad++;
            $display("FAIL R9 unexpected strobe actual=%h expected=0", op_pulse);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " R2 strobe code"}, {22'd0, op_pulse}, 32'd1 << e.idx);
            if (e.cd) chk({e.tag, " word"}, {18'd0, wdata}, {18'd0, e.d});
         end
      end
      prev_op = op_pulse;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      wclk(10);
      chk("R1 reset oe", {31'd0, sdat_pin_oe}, 32'd0);
      chk("R1 reset strobes", {22'd0, op_pulse}, 32'd0);
      rst_n = 1'b1;
      wclk(5);
      chk("R1 idle while prog_en low", {31'd0, sdat_pin_oe}, 32'd0);
      prog_en = 1'b1;
      wclk(5);

      do_load(6'b000000, 0, 14'h2A5C, 1'b0, "R4 load cfg");
      do_load(6'b000010, 1, 14'h3FFF, 1'b0, "R4 load pgm ones");
      do_load(6'b000010, 1, 14'h0001, 1'b0, "R4 load pgm lsb");
      do_load(6'b000010, 1, 14'h2001, 1'b0, "R4 load pgm ends");
      do_load(6'b000011, 2, 14'h3E5A, 1'b1, "R5 load dmem");

      expect_op(5, '0, 1'b0, "R3 increment");      send_cmd(6'b000110);
      expect_op(6, '0, 1'b0, "R3 begin erase+pgm"); send_cmd(6'b001000);
      expect_op(7, '0, 1'b0, "R3 begin pgm only");  send_cmd(6'b011000);
      expect_op(8, '0, 1'b0, "R3 erase pgm");       send_cmd(6'b001001);
      expect_op(9, '0, 1'b0, "R3 erase dat");       send_cmd(6'b001011);

      do_read(6'b000100, 3, 14'h2C71, 1'b0);
      do_read(6'b000101, 4, 14'h3FA5, 1'b1);

      // R9: unknown codes consume six cycles only
      send_cmd(6'b010101);
      send_cmd(6'b111111);
      expect_op(5, '0, 1'b0, "R9 command after unknown"); send_cmd(6'b000110);
      chk("R9 queue drained", q.size(), 32'd0);

      // R1: abort a partial command
      scyc(1'b0); scyc(1'b1); scyc(1'b1);
      prog_en = 1'b0;
      wclk(6);
      prog_en = 1'b1;
      wclk(6);
      expect_op(5, '0, 1'b0, "R1 fresh command after re-entry"); send_cmd(6'b000110);

      // R1: abort a read while the pin is driven
      rdata = 14'h1555;
      expect_op(3, '0, 1'b0, "R1 read before abort");
      send_cmd(6'b000100);
      for (int k = 1; k <= 3; k++) scyc(1'b0);
      sclk_pin = 1'b1;
      wclk(5);
      chk("R1 oe high before abort", {31'd0, sdat_pin_oe}, 32'd1);
      prog_en = 1'b0;
      wclk(3);
      chk("R1 oe released when leaving mode", {31'd0, sdat_pin_oe}, 32'd0);
      sclk_pin = 1'b0;
      wclk(6);
      prog_en = 1'b1;
      wclk(6);
      do_load(6'b000010, 1, 14'h1234, 1'b0, "R1 load after abort");

      wclk(20);
      chk("R10 all strobes seen", q.size(), 32'd0);
      summary();
   end
endmodule